// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block holds the floating-point operand storage for a processor core: two physical banks of sixteen 32-bit registers, and a 32-bit control register that decides how those banks are addressed. Every access names a logical register number together with a front/back select. A mode bit in the control register chooses which physical bank answers as the front set and which as the back set. Flipping that bit exchanges the two sets at once, with no data moved.

A second mode bit sets the transfer width. In single mode each access moves one 32-bit register, carried on the low half of a 64-bit data word. In pair mode each access moves an aligned even/odd pair as 64 bits. The even register holds the upper half and the odd register the lower half. A pair write to an odd register number is refused and flagged.

The block has two combinational read ports, one write port and one control-register port. A control-register write takes effect from the following cycle. Register writes and reads in the same cycle as that write therefore still use the old mapping and width. Precision and denormal-handling bits are stored for the arithmetic units and are not acted on here.

Top module: `banked_fpr_file`

## Requirements
- R1: While `rst` is high at a clock edge, the control register becomes 0x00040001 and every register in both banks becomes 0. `wr_err` is 0 when no write is requested.
- R2: A control write stores bits 21..0 of `ctl_wdata`. Bits 31..22 always read as 0. The stored value appears on `ctl_rdata` on the cycle after the write.
- R3: During the cycle in which a control write is issued, reads use the previous bank mapping and transfer width, and `ctl_rdata` shows the previous value.
- R4: When control bit 21 is 0, front accesses (select 0) reach bank 0 and back accesses (select 1) reach bank 1. A write to one set leaves the same number in the other set unchanged.
- R5: When control bit 21 is 1, front accesses reach bank 1 and back accesses reach bank 0, so earlier contents appear exchanged between the two sets.
- R6: When control bit 20 is 0, a write stores `wr_data[31:0]` into the addressed register and ignores `wr_data[63:32]`. A read returns the register in bits 31..0, with bits 63..32 at 0.
- R7: When control bit 20 is 1, a write to an even number stores `wr_data[63:32]` into that register and `wr_data[31:0]` into the next odd register. A read returns {even, odd}, and bit 0 of the read number is ignored.
- R8: When control bit 20 is 1, a write to an odd number drives `wr_err` high in that cycle and changes no register.
- R9: A register write issued in the same cycle as a control write uses the mapping and width in force before that control write.
- R10: Reads are combinational. A read of the register being written in the same cycle returns its old value, and the new value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | 32 | Control-register write value |
| ctl_rdata | output | 32 | Current control-register value |
| ra_idx | input | 4 | Read port A logical register number |
| ra_back | input | 1 | Read port A set select (0 front, 1 back) |
| ra_data | output | 64 | Read port A data |
| rb_idx | input | 4 | Read port B logical register number |
| rb_back | input | 1 | Read port B set select |
| rb_data | output | 64 | Read port B data |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Write logical register number |
| wr_back | input | 1 | Write set select |
| wr_data | input | 64 | Write data (low half only in single mode) |
| wr_err | output | 1 | Pair-mode write to an odd number was refused |

## Verification
The hardest case is a register write in the same cycle as a control write that changes both the bank mapping and the transfer width. The stimulus starts in pair mode with the normal mapping. In one cycle it writes a 64-bit pair to the front set and, in the same cycle, sets the control register to swapped single mode. It then reads the two halves back one by one through the back set. This shows that the pair went into bank 0 under the old rules. A same-cycle read during a control change, and a read of a register while it is being written, are set up in the same way.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int CTL_W       = 32;
    localparam int BIT_SWAP    = 21;
    localparam int BIT_PAIR    = 20;
    localparam int BIT_DBL     = 19;
    localparam int BIT_FTZ     = 18;
    localparam logic [CTL_W-1:0] CTL_RESET = 32'h0004_0001;
    localparam logic [CTL_W-1:0] CTL_WMASK = 32'h003F_FFFF;

    typedef struct packed {
        logic [9:0]  rsvd;
        logic        bank_swap;
        logic        pair_mode;
        logic        dbl_prec;
        logic        flush_denorm;
        logic [17:0] misc;
    } fpr_ctl_t;

    function automatic logic phys_bank(input logic back, input logic swap);
        return back ^ swap;
    endfunction

endpackage

// File: rtl/fpr_ctrl_reg.sv
module fpr_ctrl_reg
    import fpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output fpr_ctl_t         q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= fpr_ctl_t'(CTL_RESET);
        else if (we)
            q <= fpr_ctl_t'(wdata & CTL_WMASK);
    end

    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q == fpr_ctl_t'(CTL_RESET)));

    p_ctl_store_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == fpr_ctl_t'($past(wdata) & CTL_WMASK)));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        q.rsvd == '0);

    p_ctl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/fpr_port_map.sv
module fpr_port_map #(
    parameter int IDX_W = 4
) (
    input  logic             swap,
    input  logic [IDX_W-1:0] idx,
    input  logic             back,
    output logic             bank,
    output logic [IDX_W-2:0] pair,
    output logic             odd
);
    import fpr_pkg::*;

    always_comb begin
        bank = phys_bank(back, swap);
        pair = idx[IDX_W-1:1];
        odd  = idx[0];
    end

endmodule

// File: rtl/fpr_bank.sv
module fpr_bank #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we_even,
    input  logic                we_odd,
    input  logic [PIDX_W-1:0]   wr_pair,
    input  logic [DATA_W-1:0]   d_even,
    input  logic [DATA_W-1:0]   d_odd,
    input  logic [PIDX_W-1:0]   ra_pair,
    output logic [DATA_W-1:0]   ra_even,
    output logic [DATA_W-1:0]   ra_odd,
    input  logic [PIDX_W-1:0]   rb_pair,
    output logic [DATA_W-1:0]   rb_even,
    output logic [DATA_W-1:0]   rb_odd
);
    localparam int PAIRS  = NUM_REGS / 2;
    localparam int PIDX_W = $clog2(PAIRS);

    logic [DATA_W-1:0] mem_even [PAIRS];
    logic [DATA_W-1:0] mem_odd  [PAIRS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAIRS; i++) begin
                mem_even[i] <= '0;
                mem_odd[i]  <= '0;
            end
        end else begin
            if (we_even) mem_even[wr_pair] <= d_even;
            if (we_odd)  mem_odd[wr_pair]  <= d_odd;
        end
    end

    assign ra_even = mem_even[ra_pair];
    assign ra_odd  = mem_odd[ra_pair];
    assign rb_even = mem_even[rb_pair];
    assign rb_odd  = mem_odd[rb_pair];

    p_even_write_r6: assert property (@(posedge clk) disable iff (rst)
        we_even |=> (mem_even[$past(wr_pair)] == $past(d_even)));

    p_odd_write_r7: assert property (@(posedge clk) disable iff (rst)
        we_odd |=> (mem_odd[$past(wr_pair)] == $past(d_odd)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!we_even && !we_odd) |=> ($stable(mem_even[0]) && $stable(mem_odd[0])));

endmodule

// File: rtl/banked_fpr_file.sv
module banked_fpr_file
    import fpr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int PIDX_W  = IDX_W - 1,
    localparam int XFER_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic              ra_back,
    output logic [XFER_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic              rb_back,
    output logic [XFER_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_back,
    input  logic [XFER_W-1:0] wr_data,
    output logic              wr_err
);
    localparam int NBANK = 2;

    fpr_ctl_t ctl;

    fpr_ctrl_reg u_ctl (
        .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .q(ctl)
    );
    assign ctl_rdata = ctl;

    // logical-to-physical decode for each port
    logic              a_bank, b_bank, w_bank;
    logic [PIDX_W-1:0] a_pair, b_pair, w_pair;
    logic              a_odd, b_odd, w_odd;

    fpr_port_map #(.IDX_W(IDX_W)) u_map_a (
        .swap(ctl.bank_swap), .idx(ra_idx), .back(ra_back),
        .bank(a_bank), .pair(a_pair), .odd(a_odd)
    );
    fpr_port_map #(.IDX_W(IDX_W)) u_map_b (
        .swap(ctl.bank_swap), .idx(rb_idx), .back(rb_back),
        .bank(b_bank), .pair(b_pair), .odd(b_odd)
    );
    fpr_port_map #(.IDX_W(IDX_W)) u_map_w (
        .swap(ctl.bank_swap), .idx(wr_idx), .back(wr_back),
        .bank(w_bank), .pair(w_pair), .odd(w_odd)
    );

    // write decode
    logic              pair_on;
    logic              wr_ok;
    logic [DATA_W-1:0] d_even, d_odd;
    logic [NBANK-1:0]  we_even_v, we_odd_v;

    always_comb begin
        pair_on = ctl.pair_mode;
        wr_err  = wr_en && pair_on && w_odd;
        wr_ok   = wr_en && !wr_err;
        d_even  = pair_on ? wr_data[XFER_W-1:DATA_W] : wr_data[DATA_W-1:0];
        d_odd   = wr_data[DATA_W-1:0];
    end

    logic [DATA_W-1:0] ra_even_v [NBANK];
    logic [DATA_W-1:0] ra_odd_v  [NBANK];
    logic [DATA_W-1:0] rb_even_v [NBANK];
    logic [DATA_W-1:0] rb_odd_v  [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign we_even_v[g] = wr_ok && (w_bank == g[0]) && (pair_on || !w_odd);
        assign we_odd_v[g]  = wr_ok && (w_bank == g[0]) && (pair_on ||  w_odd);

        fpr_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
            .clk(clk), .rst(rst),
            .we_even(we_even_v[g]), .we_odd(we_odd_v[g]),
            .wr_pair(w_pair), .d_even(d_even), .d_odd(d_odd),
            .ra_pair(a_pair), .ra_even(ra_even_v[g]), .ra_odd(ra_odd_v[g]),
            .rb_pair(b_pair), .rb_even(rb_even_v[g]), .rb_odd(rb_odd_v[g])
        );
    end

    // read assembly
    always_comb begin
        if (pair_on) begin
            ra_data = {ra_even_v[a_bank], ra_odd_v[a_bank]};
            rb_data = {rb_even_v[b_bank], rb_odd_v[b_bank]};
        end else begin
            ra_data = {{DATA_W{1'b0}}, a_odd ? ra_odd_v[a_bank] : ra_even_v[a_bank]};
            rb_data = {{DATA_W{1'b0}}, b_odd ? rb_odd_v[b_bank] : rb_even_v[b_bank]};
        end
    end

    p_odd_refused_r8: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> (we_even_v == '0 && we_odd_v == '0));

    p_one_bank_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({|(we_even_v | we_odd_v) & 1'b1 & we_even_v[1] | we_odd_v[1],
                  we_even_v[0] | we_odd_v[0]}));

    p_single_one_reg_r6: assert property (@(posedge clk) disable iff (rst)
        !ctl.pair_mode |-> $onehot0({we_even_v, we_odd_v}));

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !ctl.pair_mode |-> (ra_data[XFER_W-1:DATA_W] == '0 && rb_data[XFER_W-1:DATA_W] == '0));

endmodule

// File: tb/banked_fpr_file_test.sv
module banked_fpr_file_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [31:0] ctl_wdata;
    logic [31:0] ctl_rdata;
    logic [3:0]  ra_idx, rb_idx, wr_idx;
    logic        ra_back, rb_back, wr_back, wr_en, wr_err;
    logic [63:0] ra_data, rb_data, wr_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    banked_fpr_file uut (
        .clk(clk), .rst(rst),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .ra_idx(ra_idx), .ra_back(ra_back), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_back(rb_back), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_back(wr_back), .wr_data(wr_data),
        .wr_err(wr_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl_set(input logic [31:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic back, input logic [63:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_back = back; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, input logic back, output logic [63:0] d);
        ra_idx = idx; ra_back = back;
        #1;
        d = ra_data;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        chk("R1 ctl reset", {32'h0, ctl_rdata}, 64'h0004_0001);
        chk("R1 wr_err idle", {63'h0, wr_err}, 64'h0);
        for (int i = 0; i < 16; i++) begin
            rd(i[3:0], 1'b0, d); chk("R1 front zero", d, 64'h0);
            rd(i[3:0], 1'b1, d); chk("R1 back zero", d, 64'h0);
        end
    endtask

    task automatic t_single();
        logic [63:0] d;
        wr(4'd3, 1'b0, 64'hFFFF_0000_A5A5_0003);
        rd(4'd3, 1'b0, d); chk("R6 single write/read", d, 64'h0000_0000_A5A5_0003);
        rd(4'd3, 1'b1, d); chk("R4 back untouched", d, 64'h0);
        wr(4'd3, 1'b1, 64'h0000_0000_1111_2222);
        rd(4'd3, 1'b1, d); chk("R4 back write", d, 64'h0000_0000_1111_2222);
        rd(4'd3, 1'b0, d); chk("R4 front kept", d, 64'h0000_0000_A5A5_0003);
    endtask

    task automatic t_swap();
        logic [63:0] d;
        ctl_set(32'h0024_0001);
        rd(4'd3, 1'b0, d); chk("R5 front is bank1", d, 64'h0000_0000_1111_2222);
        rd(4'd3, 1'b1, d); chk("R5 back is bank0", d, 64'h0000_0000_A5A5_0003);
    endtask

    task automatic t_ctl();
        logic [63:0] d;
        ctl_we = 1'b1; ctl_wdata = 32'hFFDF_FFFF;
        rd(4'd3, 1'b0, d); chk("R3 old mapping same cycle", d, 64'h0000_0000_1111_2222);
        chk("R3 old ctl same cycle", {32'h0, ctl_rdata}, 64'h0024_0001);
        tick();
        ctl_we = 1'b0;
        chk("R2 masked ctl", {32'h0, ctl_rdata}, 64'h001F_FFFF);
        rd(4'd3, 1'b0, d); chk("R3 new mapping next cycle", d, 64'h0000_0000_A5A5_0003);
    endtask

    task automatic t_pair();
        logic [63:0] d;
        ctl_set(32'h0010_0000);
        wr(4'd4, 1'b0, 64'h0123_4567_89AB_CDEF);
        rd(4'd4, 1'b0, d); chk("R7 pair read", d, 64'h0123_4567_89AB_CDEF);
        rd(4'd5, 1'b0, d); chk("R7 pair bit0 ignored", d, 64'h0123_4567_89AB_CDEF);
        ctl_set(32'h0000_0000);
        rd(4'd4, 1'b0, d); chk("R7 even holds upper", d, 64'h0000_0000_0123_4567);
        rd(4'd5, 1'b0, d); chk("R7 odd holds lower", d, 64'h0000_0000_89AB_CDEF);
    endtask

    task automatic t_odd();
        logic [63:0] d;
        ctl_set(32'h0010_0000);
        wr_en = 1'b1; wr_idx = 4'd7; wr_back = 1'b0; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        #1;
        chk("R8 wr_err raised", {63'h0, wr_err}, 64'h1);
        tick();
        wr_en = 1'b0;
        #1;
        chk("R8 wr_err clears", {63'h0, wr_err}, 64'h0);
        rd(4'd6, 1'b0, d); chk("R8 no write front", d, 64'h0);
        rd(4'd6, 1'b1, d); chk("R8 no write back", d, 64'h0);
    endtask

    task automatic t_same_cycle();
        logic [63:0] d;
        ctl_we = 1'b1; ctl_wdata = 32'h0020_0000;
        wr_en = 1'b1; wr_idx = 4'd8; wr_back = 1'b0; wr_data = 64'hDEAD_BEEF_CAFE_F00D;
        tick();
        ctl_we = 1'b0; wr_en = 1'b0;
        chk("R9 ctl applied", {32'h0, ctl_rdata}, 64'h0020_0000);
        rd(4'd8, 1'b1, d); chk("R9 even to old bank", d, 64'h0000_0000_DEAD_BEEF);
        rd(4'd9, 1'b1, d); chk("R9 odd to old bank", d, 64'h0000_0000_CAFE_F00D);
        rd(4'd8, 1'b0, d); chk("R9 new front empty", d, 64'h0);
    endtask

    task automatic t_bypass();
        wr_en = 1'b1; wr_idx = 4'd10; wr_back = 1'b0; wr_data = 64'h0000_0000_0000_5555;
        rb_idx = 4'd10; rb_back = 1'b0;
        #1;
        chk("R10 old value same cycle", rb_data, 64'h0);
        tick();
        wr_en = 1'b0;
        #1;
        chk("R10 new value next cycle", rb_data, 64'h0000_0000_0000_5555);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; wr_en = 1'b0;
        wr_idx = '0; wr_back = 1'b0; wr_data = '0;
        ra_idx = '0; ra_back = 1'b0; rb_idx = '0; rb_back = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        tick();
        t_single();
        t_swap();
        t_ctl();
        t_pair();
        t_odd();
        t_same_cycle();
        t_bypass();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule